// File: doc/BRIEF.md
# Power-Management Interval Timer

This block keeps a free-running 24-bit tick count for platform power management and presents it as a read-only 32-bit word on a simple register-read port. It lives entirely in the bus clock domain. The slow reference clock (nominally 14.31818 MHz) is treated as a data input: it is oversampled, its rising edges are detected, and a divide-by-four prescaler turns every fourth edge into a one-cycle advance pulse. The resulting count rate is the nominal 3.579545 MHz.

The count advances only while the working-state indication is asserted. That indication is a level input passed through a two-stage synchroniser. When the platform drops into a light sleep state the indication falls and the count freezes. It is not cleared, so counting picks up from the frozen value on return. Only the synchronous platform reset returns the count to zero. Each time count bit 22 goes from one to zero as the count advances, a sticky rollover flag is raised. Software clears the flag with a dedicated strobe. A read captures the whole count into the read-data register in a single edge, so the value returned is always one coherent snapshot.

Top module: `pmt_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count, `rd_data`, `rd_valid` and `tmrof_sts` all go to zero at that edge.
- R2: Each rising edge of `ref_clk_in` is sampled through two flops and detected against a third. The count advances by exactly one on every fourth detected edge, counted from reset, and only if the synchronised working-state level is high.
- R3: `s0_active` reaches the counting logic two bus cycles after it is sampled. While the synchronised level is low, the count holds its value and the prescaler phase keeps running. When the level returns high, counting resumes from the held value and does not restart from zero.
- R4: The count wraps modulo 2^CNT_W: the all-ones value advances to zero.
- R5: A `bus_rd` sampled at edge k makes `rd_valid` high after edge k and loads `rd_data` with the count held just before edge k, zero-extended. Bits 31:24 read zero. `rd_data` keeps its value between reads.
- R6: `bus_wr` has no effect on the count, the flag or the read data.
- R7: `tmrof_sts` is set at the same edge at which the count advances from a value with bit CNT_W-2 (bit 22 by default) set to one with that bit clear. A zero-to-one change of that bit never sets the flag.
- R8: `tmrof_sts` stays set until an edge at which `sts_clr` is high. If a setting event and `sts_clr` fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high platform reset |
| ref_clk_in | input | 1 | Raw reference clock, sampled as data |
| s0_active | input | 1 | Level: high while the platform is in the working state |
| bus_rd | input | 1 | Read strobe for the timer register |
| bus_wr | input | 1 | Write strobe to the timer register, ignored |
| sts_clr | input | 1 | Write-one-to-clear strobe for the rollover flag |
| rd_data | output | 32 | Zero-extended count snapshot from the last read |
| rd_valid | output | 1 | High for the cycle after a read strobe |
| tmrof_sts | output | 1 | Sticky rollover flag for counter bit CNT_W-2 |

## Verification
The collision that matters is a falling edge of the flagged counter bit in the same cycle as a software clear. The bench runs a second instance with a 10-bit count so that bit 8 falls twice within a practical run, at 0x1FF to 0x200 and at 0x3FF to 0x000. Its behavioural model predicts the advance one cycle ahead, and on the first fall the bench drives the clear strobe into exactly that edge. The flag must then stay set. A later clear with no event must drop it, and the second fall must set it again. The zero-to-one changes of bit 8 are compared with the flag on every clock to catch any false set.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int unsigned PMT_REG_W = 32;

    typedef enum logic {
        PWR_SLEEPING = 1'b0,
        PWR_WORKING  = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic                 valid;
        logic [PMT_REG_W-1:0] data;
    } rd_rsp_t;

    // true when an increment from cur to nxt drops the watched bit
    function automatic logic bit_fell(input logic cur_bit, input logic nxt_bit);
        return cur_bit & ~nxt_bit;
    endfunction

endpackage

// File: rtl/pmt_sync.sv
module pmt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pmt_tick_gen.sv
module pmt_tick_gen #(
    parameter int unsigned DIV         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_raw,
    output logic tick
);
    localparam int unsigned PS_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(DIV - 1);

    logic            ref_q;
    logic            ref_prev;
    logic            ref_rise;
    logic [PS_W-1:0] phase;

    pmt_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk (clk),
        .rst (rst),
        .d   (ref_raw),
        .q   (ref_q)
    );

    always_ff @(posedge clk) begin
        if (rst) ref_prev <= 1'b0;
        else     ref_prev <= ref_q;
    end

    assign ref_rise = ref_q & ~ref_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (ref_rise) begin
            if (phase == PS_LAST) phase <= '0;
            else                  phase <= phase + 1'b1;
        end
    end

    assign tick = ref_rise && (phase == PS_LAST);

    // an edge detector can never report two rises back to back
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("tick lasted two cycles"); // R2

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int unsigned CNT_W   = 24,
    parameter int unsigned FLAG_AT = CNT_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             sts
);
    import pmt_pkg::*;

    logic [CNT_W-1:0] count_nxt;
    logic             fall;

    assign count_nxt = count + 1'b1;
    assign fall      = adv & bit_fell(count[FLAG_AT], count_nxt[FLAG_AT]);

    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (adv) count <= count_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) sts <= 1'b0;
        else     sts <= fall | (sts & ~clr);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1))
        else $error("count jumped"); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(count)) else $error("count moved while idle"); // R3

    AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
        (adv && count[FLAG_AT] && !count_nxt[FLAG_AT]) |=> sts)
        else $error("flag missed a fall"); // R7

    AST_STS_KEEP: assert property (@(posedge clk) disable iff (rst)
        (sts && !clr) |=> sts) else $error("flag dropped without clear"); // R8

    AST_STS_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sts) |-> $past(adv)) else $error("flag set without advance"); // R7

endmodule

// File: rtl/pmt_readout.sv
module pmt_readout #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic [CNT_W-1:0] count,
    output pmt_pkg::rd_rsp_t rsp
);
    import pmt_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp <= '0;
        end else begin
            rsp.valid <= rd;
            if (rd) rsp.data <= PMT_REG_W'(count);
        end
    end

    AST_RD_UPPER: assert property (@(posedge clk) disable iff (rst)
        rsp.valid |-> (rsp.data >> CNT_W) == '0) else $error("upper bits set"); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rsp.data)) else $error("read data moved"); // R5

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer #(
    parameter int unsigned CNT_W       = 24,
    parameter int unsigned DIV         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_clk_in,
    input  logic        s0_active,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        sts_clr,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        tmrof_sts
);
    import pmt_pkg::*;

    localparam int unsigned FLAG_AT = CNT_W - 2;

    logic             tick;
    logic             pwr_raw;
    pwr_state_e       pwr;
    logic             adv;
    logic [CNT_W-1:0] count;
    rd_rsp_t          rsp;

    pmt_tick_gen #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .ref_raw (ref_clk_in),
        .tick    (tick)
    );

    pmt_sync #(.STAGES(SYNC_STAGES)) u_pwr_sync (
        .clk (clk),
        .rst (rst),
        .d   (s0_active),
        .q   (pwr_raw)
    );

    assign pwr = pwr_state_e'(pwr_raw);
    assign adv = tick && (pwr == PWR_WORKING);

    pmt_counter #(.CNT_W(CNT_W), .FLAG_AT(FLAG_AT)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .clr   (sts_clr),
        .count (count),
        .sts   (tmrof_sts)
    );

    pmt_readout #(.CNT_W(CNT_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .count (count),
        .rsp   (rsp)
    );

    assign rd_data  = rsp.data;
    assign rd_valid = rsp.valid;

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !adv) |=> $stable(count)) else $error("write moved count"); // R6

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (pwr == PWR_SLEEPING) |=> $stable(count)) else $error("count ran asleep"); // R3

endmodule

// File: tb/sim_pmt_timer.sv
`timescale 1ns/1ps

module pmt_ref_model #(
    parameter int W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_in,
    input  logic        s0,
    input  logic        rd,
    input  logic        clr,
    output logic [31:0] exp_rd,
    output logic        exp_valid,
    output logic        exp_sts,
    output int          exp_cnt,
    output logic        fall_next
);
    logic rq[$];
    logic sq[$];
    int   edges;
    int   mask;
    int   fb;

    function automatic logic will_fall(int c);
        int n;
        n = (c + 1) & mask;
        return ((c >> fb) & 1) == 1 && ((n >> fb) & 1) == 0;
    endfunction

    function automatic logic advance_now();
        return rq[1] && !rq[2] && (edges % 4 == 3) && sq[1];
    endfunction

    initial begin
        mask = (1 << W) - 1;
        fb = W - 2;
        rq = '{1'b0, 1'b0, 1'b0};
        sq = '{1'b0, 1'b0};
        edges = 0; exp_cnt = 0; exp_rd = 0; exp_valid = 0; exp_sts = 0;
        fall_next = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            rq = '{1'b0, 1'b0, 1'b0};
            sq = '{1'b0, 1'b0};
            edges = 0; exp_cnt = 0; exp_rd = 0; exp_valid = 0; exp_sts = 0;
        end else begin
            logic adv, f;
            adv = advance_now();
            f = adv && will_fall(exp_cnt);
            exp_valid = rd;
            if (rd) exp_rd = exp_cnt;
            exp_sts = f || (exp_sts && !clr);
            if (adv) exp_cnt = (exp_cnt + 1) & mask;
            if (rq[1] && !rq[2]) edges++;
            rq.push_front(ref_in); void'(rq.pop_back());
            sq.push_front(s0);     void'(sq.pop_back());
        end
        fall_next = advance_now() && will_fall(exp_cnt);
    end
endmodule

module sim_pmt_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk = 1'b0;
    logic s0 = 1'b0;
    logic rd = 1'b0;
    logic wr = 1'b0;
    logic clr0 = 1'b0;
    logic clr1 = 1'b0;
    logic man_clr1 = 1'b0;
    logic coin_en = 1'b0;

    logic [31:0] rd_data0, rd_data1, m_rd0, m_rd1;
    logic        rv0, rv1, sts0, sts1, m_v0, m_v1, m_s0, m_s1, fn0, fn1;
    int          mc0, mc1;

    int checks = 0;
    int failures = 0;
    int coin_hits = 0;
    int u1_sets = 0;
    logic prev_sts1 = 1'b0;
    logic [31:0] held;

    always #2.5 clk = ~clk;
    always #20  ref_clk = ~ref_clk;

    pmt_timer u0 (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk), .s0_active(s0),
        .bus_rd(rd), .bus_wr(wr), .sts_clr(clr0),
        .rd_data(rd_data0), .rd_valid(rv0), .tmrof_sts(sts0)
    );

    pmt_timer #(.CNT_W(10)) u1 (
        .clk(clk), .rst(rst), .ref_clk_in(ref_clk), .s0_active(s0),
        .bus_rd(rd), .bus_wr(wr), .sts_clr(clr1),
        .rd_data(rd_data1), .rd_valid(rv1), .tmrof_sts(sts1)
    );

    pmt_ref_model #(.W(24)) m0 (
        .clk(clk), .rst(rst), .ref_in(ref_clk), .s0(s0), .rd(rd), .clr(clr0),
        .exp_rd(m_rd0), .exp_valid(m_v0), .exp_sts(m_s0), .exp_cnt(mc0), .fall_next(fn0)
    );

    pmt_ref_model #(.W(10)) m1 (
        .clk(clk), .rst(rst), .ref_in(ref_clk), .s0(s0), .rd(rd), .clr(clr1),
        .exp_rd(m_rd1), .exp_valid(m_v1), .exp_sts(m_s1), .exp_cnt(mc1), .fall_next(fn1)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (!rst) begin
            check(rd_data0 == m_rd0, "R2 R5 u0 rd_data", rd_data0, m_rd0);
            check(rv0 == m_v0, "R5 u0 rd_valid", rv0, m_v0);
            check(sts0 == m_s0, "R7 R8 u0 sts", sts0, m_s0);
            check(rd_data1 == m_rd1, "R2 R4 R5 u1 rd_data", rd_data1, m_rd1);
            check(rv1 == m_v1, "R5 u1 rd_valid", rv1, m_v1);
            check(sts1 == m_s1, "R7 R8 u1 sts", sts1, m_s1);
            check(rd_data0[31:24] == 8'h00, "R5 upper zero", rd_data0[31:24], 0);
            if (sts1 && !prev_sts1) u1_sets++;
            if (clr1 && fn1 === 1'b0 && coin_en) ; // nothing
        end
        prev_sts1 <= sts1;
        clr1 <= (coin_en & fn1) | man_clr1;
        if (coin_en && fn1) coin_hits++;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rd = 1'b1;
        cycles(6);
        check(rd_data0 == 0 && sts0 == 0 && rv0 == 0, "R1 reset u0", rd_data0, 0);
        check(rd_data1 == 0 && sts1 == 0 && rv1 == 0, "R1 reset u1", rd_data1, 0);
        rst = 1'b0;
        s0 = 1'b1;
        cycles(400);
        check(rd_data0 != 0, "R2 counting started", rd_data0, m_rd0);
        for (int i = 0; i < 20; i++) begin
            wr = 1'b1; cycles(1); wr = 1'b0; cycles(7);
        end
        s0 = 1'b0;
        cycles(4);
        held = rd_data0;
        for (int i = 0; i < 10; i++) begin
            wr = 1'b1; cycles(1); wr = 1'b0; cycles(30);
        end
        check(rd_data0 == held, "R3 R6 held while sleeping", rd_data0, held);
        s0 = 1'b1;
        cycles(200);
        check(rd_data0 > held, "R3 resumed from held value", rd_data0, held);
        rst = 1'b1; cycles(2);
        check(rd_data0 == 0 && rd_data1 == 0, "R1 mid-run reset", rd_data0, 0);
        rst = 1'b0;
        coin_en = 1'b1;
        cycles(520 * 32);
        coin_en = 1'b0;
        check(coin_hits == 1, "R8 clear collided with fall", coin_hits, 1);
        check(sts1 == 1'b1, "R8 set wins over clear", sts1, 1);
        man_clr1 = 1'b1; cycles(1); man_clr1 = 1'b0; cycles(2);
        check(sts1 == 1'b0, "R8 clear drops flag", sts1, 0);
        cycles(520 * 32);
        check(sts1 == 1'b1, "R4 R7 flag after wrap to zero", sts1, 1);
        check(u1_sets == 2, "R7 exactly two set events", u1_sets, 2);
        check(sts0 == 1'b0, "R7 no set on 24-bit instance", sts0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule